// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers level-sensitive interrupt request lines from peripherals and drives a single interrupt line to the processor. Inside, two identical eight-input arbitration units are chained. The secondary unit's interrupt output takes the place of input 2 of the primary unit, so fifteen device sources remain. The request lines are sampled into a register. Each unit masks its requests, resolves a fixed priority among them, and holds back any request that does not outrank the source it is currently serving.

When the processor sees `int_out` high, it pulses `bus_ack`. On the next cycle `bus_rdata` holds an 8-bit vector that names the winning source, and the winner is marked as in service. Software clears the in-service bit later with an end-of-interrupt write. Software can also change each unit's vector base and mask through a small write interface.

Top module: `cascade_pic`

## Requirements
- R1: A request line driven high (1 = request) is sampled at one clock edge and drives `int_out` high at the next edge, provided it is unmasked and outranks every in-service source. `int_out` is registered.
- R2: After a synchronous reset, `int_out` and `bus_rdata` are 0, both masks are 0 (all lines enabled), nothing is in service, and the bases are 0x08 (primary) and 0x70 (secondary).
- R3: The vector is the owning unit's base with bits [2:0] replaced by the input index within that unit. With reset bases, line i (0..7) gives 0x08+i and line i (8..15) gives 0x70+(i-8).
- R4: A lower-numbered input beats a higher-numbered one. All secondary lines (8..15) rank below lines 0 and 1 and above lines 3..7.
- R5: A write to address 2 (primary) or address 3 (secondary) loads the mask, where bit k masks input k of that unit. A masked line never raises `int_out` and never wins.
- R6: An acknowledge marks the winner as in service. Requests of equal or lower priority in that unit are then held off, while a higher-priority request still raises `int_out` and can be acknowledged (nesting).
- R7: A write to address 4 (primary) or address 5 (secondary) clears the in-service bit whose index is given by `bus_wdata[2:0]`.
- R8: A secondary win returns the secondary vector and marks both the secondary source and primary input 2 as in service. `irq_in[2]` has no effect.
- R9: An acknowledge while no request is eligible returns the primary base with bits [2:0] = 7, and it marks nothing in service.
- R10: A write to address 0 (primary) or address 1 (secondary) loads that unit's vector base. Later acknowledges use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Device request lines; bit 2 unused |
| int_out | output | 1 | Interrupt request to the processor |
| bus_addr | input | 3 | Write address (0..5) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_ack | input | 1 | Acknowledge pulse; captures a vector |
| bus_rdata | output | 8 | Vector captured at the last acknowledge |

## Verification
The bench builds the block with its default parameters: eight inputs per unit, the cascade on primary input 2, and reset bases 0x08 and 0x70. This is the shape the fixed vector expectations depend on. With these values the bench can reach nesting through the cascade line and the double in-service marking on a secondary win. It also covers the held-off state that follows a secondary end-of-interrupt written without the matching primary one, and the rebasing of both units to non-default vectors.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
  typedef enum logic [2:0] {
    ADR_PRI_BASE = 3'd0,
    ADR_SEC_BASE = 3'd1,
    ADR_PRI_MASK = 3'd2,
    ADR_SEC_MASK = 3'd3,
    ADR_PRI_EOI  = 3'd4,
    ADR_SEC_EOI  = 3'd5
  } cpic_addr_e;
endpackage

// File: rtl/cpic_lowest.sv
module cpic_lowest #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cpic_unit.sv
module cpic_unit #(
  parameter int         N        = 8,
  parameter int         IW       = $clog2(N),
  parameter logic [7:0] BASE_RST = 8'h08
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          base_we,
  input  logic          mask_we,
  input  logic          eoi_we,
  input  logic [7:0]    wdata,
  input  logic          ack_i,
  output logic          int_o,
  output logic [IW-1:0] win_o,
  output logic [7:0]    base_o,
  output logic [N-1:0]  mask_o
);
  logic [N-1:0]  mask_q, is_q, is_nxt, pend;
  logic [7:0]    base_q;
  logic          p_any, s_any;
  logic [IW-1:0] p_idx, s_idx;

  assign pend = req_i & ~mask_q;

  cpic_lowest #(.N(N), .IW(IW)) u_pend (.vec(pend), .any(p_any), .idx(p_idx));
  cpic_lowest #(.N(N), .IW(IW)) u_serv (.vec(is_q), .any(s_any), .idx(s_idx));

  assign int_o  = p_any && (!s_any || (p_idx < s_idx));
  assign win_o  = p_idx;
  assign base_o = base_q;
  assign mask_o = mask_q;

  always_comb begin
    is_nxt = is_q;
    if (eoi_we) is_nxt[wdata[IW-1:0]] = 1'b0;
    if (ack_i && int_o) is_nxt[p_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      is_q   <= '0;
      base_q <= BASE_RST;
    end else begin
      is_q <= is_nxt;
      if (base_we) base_q <= wdata;
      if (mask_we) mask_q <= wdata[N-1:0];
    end
  end

  // R6: an accepted acknowledge leaves the winner in service
  assert_is_set_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && int_o) |=> is_q[$past(p_idx)]);

  // R7: an end-of-interrupt write without acknowledge clears the named bit
  assert_eoi_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (eoi_we && !ack_i) |=> !is_q[$past(wdata[IW-1:0])]);
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic #(
  parameter int         UNIT_N   = 8,
  parameter int         CASC     = 2,
  parameter logic [7:0] PRI_BASE = 8'h08,
  parameter logic [7:0] SEC_BASE = 8'h70
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*UNIT_N-1:0] irq_in,
  output logic                int_out,
  input  logic [2:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [7:0]          bus_wdata,
  input  logic                bus_ack,
  output logic [7:0]          bus_rdata
);
  import cpic_pkg::*;

  localparam int IW  = $clog2(UNIT_N);
  localparam int TOT = 2 * UNIT_N;

  logic [TOT-1:0]    irr_q;
  logic [UNIT_N-1:0] p_req, p_mask, s_mask;
  logic              p_int, s_int, p_ack, s_ack, casc_win;
  logic [IW-1:0]     p_win, s_win;
  logic [7:0]        p_base, s_base, vec_d;
  logic              unused_cascade_pin;
  cpic_addr_e        adr;

  assign adr                = cpic_addr_e'(bus_addr);
  assign unused_cascade_pin = irr_q[CASC];

  generate
    for (genvar i = 0; i < UNIT_N; i++) begin : g_pri_in
      if (i == CASC) begin : g_casc
        assign p_req[i] = s_int;
      end else begin : g_dev
        assign p_req[i] = irr_q[i];
      end
    end
  endgenerate

  assign casc_win = p_int && (p_win == IW'(CASC));
  assign p_ack    = bus_ack;
  assign s_ack    = bus_ack && casc_win;

  cpic_unit #(.N(UNIT_N), .IW(IW), .BASE_RST(PRI_BASE)) u_pri (
    .clk(clk), .rst(rst), .req_i(p_req),
    .base_we(bus_wr && adr == ADR_PRI_BASE),
    .mask_we(bus_wr && adr == ADR_PRI_MASK),
    .eoi_we (bus_wr && adr == ADR_PRI_EOI),
    .wdata(bus_wdata), .ack_i(p_ack),
    .int_o(p_int), .win_o(p_win), .base_o(p_base), .mask_o(p_mask));

  cpic_unit #(.N(UNIT_N), .IW(IW), .BASE_RST(SEC_BASE)) u_sec (
    .clk(clk), .rst(rst), .req_i(irr_q[TOT-1:UNIT_N]),
    .base_we(bus_wr && adr == ADR_SEC_BASE),
    .mask_we(bus_wr && adr == ADR_SEC_MASK),
    .eoi_we (bus_wr && adr == ADR_SEC_EOI),
    .wdata(bus_wdata), .ack_i(s_ack),
    .int_o(s_int), .win_o(s_win), .base_o(s_base), .mask_o(s_mask));

  always_comb begin
    if (!p_int)       vec_d = {p_base[7:IW], {IW{1'b1}}};
    else if (casc_win) vec_d = {s_base[7:IW], s_win};
    else              vec_d = {p_base[7:IW], p_win};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q     <= '0;
      int_out   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irr_q   <= irq_in;
      int_out <= p_int;
      if (bus_ack) bus_rdata <= vec_d;
    end
  end

  // R5: with every primary line masked, the output stays low
  assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (&p_mask) |=> !int_out);

  // R8: a cascade win returns the secondary unit's base
  assert_sec_vector_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && casc_win) |=> bus_rdata[7:IW] == $past(s_base[7:IW]));
endmodule

// File: tb/cascade_pic_tb.sv
module cascade_pic_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_ack = 1'b0;
  logic        int_out;
  logic [7:0]  bus_rdata;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R2";
  bit    live = 1'b0;

  always #10 clk = ~clk;

  cascade_pic u_dut (.clk(clk), .rst(rst), .irq_in(irq_in), .int_out(int_out),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  // behavioural reference state
  bit [15:0] m_irr;
  bit [7:0]  m_pmask, m_smask, m_pis, m_sis, m_pbase, m_sbase, m_rdata;
  bit        m_int;

  function automatic void decide(input bit [7:0] req, mask, serv,
                                 output bit go, output int win);
    int p = 8, s = 8;
    for (int i = 7; i >= 0; i--) begin
      if (req[i] && !mask[i]) p = i;
      if (serv[i]) s = i;
    end
    go  = (p < 8) && (p < s);
    win = p;
  endfunction

  always @(posedge clk) begin
    bit sgo, pgo;
    int sw, pw;
    bit [7:0] preq;
    if (rst) begin
      m_irr = '0; m_pmask = '0; m_smask = '0; m_pis = '0; m_sis = '0;
      m_pbase = 8'h08; m_sbase = 8'h70; m_rdata = '0; m_int = 1'b0;
    end else begin
      decide(m_irr[15:8], m_smask, m_sis, sgo, sw);
      preq = m_irr[7:0];
      preq[2] = sgo;
      decide(preq, m_pmask, m_pis, pgo, pw);
      if (bus_wr && bus_addr == 3'd4) m_pis[bus_wdata[2:0]] = 1'b0;
      if (bus_wr && bus_addr == 3'd5) m_sis[bus_wdata[2:0]] = 1'b0;
      if (bus_ack) begin
        if (!pgo) m_rdata = {m_pbase[7:3], 3'd7};
        else if (pw == 2) begin
          m_rdata = {m_sbase[7:3], 3'(sw)};
          m_pis[2] = 1'b1; m_sis[sw] = 1'b1;
        end else begin
          m_rdata = {m_pbase[7:3], 3'(pw)};
          m_pis[pw] = 1'b1;
        end
      end
      if (bus_wr && bus_addr == 3'd0) m_pbase = bus_wdata;
      if (bus_wr && bus_addr == 3'd1) m_sbase = bus_wdata;
      if (bus_wr && bus_addr == 3'd2) m_pmask = bus_wdata;
      if (bus_wr && bus_addr == 3'd3) m_smask = bus_wdata;
      m_int = pgo;
      m_irr = irq_in;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk({cur_req, " int_out vs model"}, int_out, m_int);
      chk({cur_req, " rdata vs model"}, bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ack();
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    live = 1'b1;
    chk("R2 int_out after reset", int_out, 0);
    chk("R2 rdata after reset", bus_rdata, 0);

    cur_req = "R1";
    irq_in = 16'h0002;
    idle(3);
    chk("R1 request raises int_out", int_out, 1);
    cur_req = "R3";
    ack();
    chk("R3 line 1 vector", bus_rdata, 8'h09);
    irq_in = '0;
    wr(3'd4, 8'd1);
    idle(2);

    cur_req = "R4";
    irq_in = 16'h0220;
    idle(3);
    ack();
    chk("R4 secondary beats line 5", bus_rdata, 8'h71);
    cur_req = "R6";
    irq_in = 16'h0221;
    idle(3);
    chk("R6 higher source nests", int_out, 1);
    ack();
    chk("R6 nested vector", bus_rdata, 8'h08);
    irq_in = 16'h0020;
    wr(3'd4, 8'd0);
    idle(2);
    chk("R6 line 5 held off by cascade in service", int_out, 0);
    cur_req = "R7";
    wr(3'd5, 8'd1);
    idle(2);
    chk("R7 primary bit 2 still holds line 5", int_out, 0);
    wr(3'd4, 8'd2);
    idle(2);
    chk("R7 line 5 released after both EOIs", int_out, 1);
    ack();
    chk("R7 line 5 vector", bus_rdata, 8'h0D);
    irq_in = '0;
    wr(3'd4, 8'd5);

    cur_req = "R8";
    irq_in = 16'h0004;
    idle(4);
    chk("R8 irq_in[2] ignored", int_out, 0);
    cur_req = "R9";
    ack();
    chk("R9 spurious vector", bus_rdata, 8'h0F);
    irq_in = '0;

    cur_req = "R5";
    wr(3'd2, 8'h20);
    irq_in = 16'h0020;
    idle(3);
    chk("R5 masked line 5 silent", int_out, 0);
    wr(3'd2, 8'h00);
    idle(2);
    chk("R5 unmasked line 5 raises", int_out, 1);
    ack();
    chk("R5 vector after unmask", bus_rdata, 8'h0D);
    irq_in = '0;
    wr(3'd4, 8'd5);
    wr(3'd3, 8'h10);
    irq_in = 16'h1000;
    idle(3);
    chk("R5 masked secondary line 12 silent", int_out, 0);

    cur_req = "R10";
    wr(3'd0, 8'h20);
    wr(3'd1, 8'hA8);
    wr(3'd3, 8'h00);
    idle(2);
    ack();
    chk("R10 rebased secondary vector", bus_rdata, 8'hAC);
    irq_in = '0;
    wr(3'd5, 8'd4);
    wr(3'd4, 8'd2);
    irq_in = 16'h0408;
    idle(3);
    cur_req = "R4";
    ack();
    chk("R4 secondary beats line 3", bus_rdata, 8'hAA);
    irq_in = 16'h0008;
    wr(3'd5, 8'd2);
    wr(3'd4, 8'd2);
    idle(2);
    cur_req = "R10";
    ack();
    chk("R10 rebased primary vector", bus_rdata, 8'h23);
    wr(3'd4, 8'd3);
    cur_req = "R4";
    irq_in = 16'h0102;
    idle(3);
    ack();
    chk("R4 line 1 beats secondary", bus_rdata, 8'h21);
    irq_in = '0;
    wr(3'd4, 8'd1);
    idle(3);
    finish_run();
  end
endmodule